// File: doc/BRIEF.md
# Flash block erase sequencer

This controller sits on the host side of a parallel, command-driven flash device and erases a batch of blocks without software stepping through each bus cycle. A batch is started with a block count. The controller steps an index through a caller-supplied address table, then walks the device through a fixed sequence. It first clears the device's sticky error bits. For each block it then writes the two-cycle erase command and polls the status byte until the device reports ready. At the end of the batch it returns the device to array-read mode.

The status byte can be decoded in one of two ways. In per-block mode it is decoded after every block, and the batch stops at the first failure. In deferred mode every block in the batch is erased and one decode is made at the end from the accumulated sticky bits. In both modes the decode checks the bits in a fixed priority. A poll counter guards against a device that never becomes ready. The result is a one-cycle completion pulse, together with an error code and the index of the first failing block. Both stay valid until the next batch starts.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `bus_we` and `bus_re` are 0, and `err_code` and `fail_idx` are 0.
- R2: A batch starts only when `start` is high in an idle cycle with a nonzero `blk_count`. Its first bus cycle writes data 50h (clear status). For each block index i, from 0 upwards, it then writes 20h followed by D0h, both to the address `blk_addr` supplied while `blk_idx` equals i.
- R3: Each status poll is a one-cycle read with `bus_re` high. Two consecutive polls are separated by at least one cycle with `bus_re` low, and `bus_we` and `bus_re` are never high together.
- R4: After a D0h write the controller keeps polling. Only a read with data bit 7 = 1 (ready) ends the polling for that block. Bit 7 = 0 means busy.
- R5: The status decode gives the following `err_code` values, in this priority: bit 1 set gives 1 (locked block); otherwise bit 3 set gives 2 (supply range); otherwise bits 4 and 5 both set gives 3 (command sequence); otherwise bit 5 set gives 4 (erase failure); otherwise the result is 0 (pass). Bit 4 set on its own gives pass.
- R6: With `per_block_chk` = 1, a ready status that decodes nonzero ends the batch at once. No further blocks are erased, and `fail_idx` gives that block's index.
- R7: With `per_block_chk` = 0, every block in the batch is erased. `err_code` is the decode of the last ready status. `fail_idx` is the index of the first block whose ready status decoded nonzero, or 0 if none did.
- R8: Every batch ends with a write of data FFh. `done` pulses for one cycle in the cycle after that write, with `busy` low.
- R9: If `poll_limit` consecutive polls of one block all read busy, the batch aborts with `err_code` 5 and `fail_idx` set to that block. Exactly `poll_limit` reads are made for that block, and a `poll_limit` of 0 acts as 1.
- R10: `start` is ignored while a batch is running, and it is also ignored when `blk_count` is 0. Neither case causes any bus cycle or `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a batch (sampled when idle) |
| blk_count | input | CW | Number of blocks in the batch |
| per_block_chk | input | 1 | 1: decode after each block, 0: decode once at end |
| poll_limit | input | PW | Busy polls allowed per block before timeout |
| blk_idx | output | CW | Index into the caller's address table |
| blk_addr | input | AW | Address inside block `blk_idx` |
| bus_we | output | 1 | Device write strobe |
| bus_re | output | 1 | Device read strobe |
| bus_addr | output | AW | Device address |
| bus_wdata | output | DW | Device write data |
| bus_rdata | input | DW | Device read data, status in bits 7:0 |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle batch completion pulse |
| err_code | output | 3 | 0 pass, 1 locked, 2 supply, 3 sequence, 4 erase, 5 timeout |
| fail_idx | output | CW | Index of the first failing block |

## Verification
The bench varies the decode priority by setting several status bits at once. Supply-range plus erase-fail must report supply range, and bit 4 alone must report a pass. A decoder that tests the bits in the wrong order, or that treats bit 4 alone as an error, returns the wrong code. In deferred mode an error is injected in a middle block. The bench then checks that all blocks are still erased and that the reported index is the middle one, not the last. A design that stopped early, or that latched the index on every error, would fail this check. A batch that follows a failed batch must pass, which shows that the clear-status write happens first. A timeout run counts the reads exactly, so an off-by-one in the poll counter shows up. Starts given while busy, or with a zero count, must produce no bus traffic.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] blk_count,
  input  logic          per_block_chk,
  input  logic [PW-1:0] poll_limit,
  output logic [CW-1:0] blk_idx,
  input  logic [AW-1:0] blk_addr,
  output logic          bus_we,
  output logic          bus_re,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic [2:0]    err_code,
  output logic [CW-1:0] fail_idx
);
  typedef enum logic [2:0] {S_IDLE, S_CLR, S_SETUP, S_CONF, S_POLL, S_GAP, S_FF} st_t;

  localparam logic [2:0] E_TIMEOUT = 3'd5;

  st_t           st_q;
  logic [CW-1:0] cnt_q, idx_q;
  logic [PW-1:0] lim_q, pcnt_q;
  logic          per_q, seen_q;

  function automatic logic [2:0] decode(input logic [7:0] s);
    if (s[1])             return 3'd1;
    else if (s[3])        return 3'd2;
    else if (s[4] & s[5]) return 3'd3;
    else if (s[5])        return 3'd4;
    else                  return 3'd0;
  endfunction

  logic [2:0] code;
  logic       rdy, last;
  assign code = decode(bus_rdata[7:0]);
  assign rdy  = bus_rdata[7];
  assign last = (idx_q == cnt_q - 1'b1);

  assign blk_idx  = idx_q;
  assign bus_addr = blk_addr;
  assign bus_we   = (st_q == S_CLR) || (st_q == S_SETUP) || (st_q == S_CONF) || (st_q == S_FF);
  assign bus_re   = (st_q == S_POLL);
  assign busy     = (st_q != S_IDLE);

  always_comb begin
    case (st_q)
      S_CLR:   bus_wdata = DW'(8'h50);
      S_SETUP: bus_wdata = DW'(8'h20);
      S_CONF:  bus_wdata = DW'(8'hD0);
      S_FF:    bus_wdata = DW'(8'hFF);
      default: bus_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; idx_q <= '0; lim_q <= '0; pcnt_q <= '0;
      per_q <= 1'b0; seen_q <= 1'b0; done <= 1'b0; err_code <= '0; fail_idx <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        S_IDLE: if (start && blk_count != '0) begin
          cnt_q <= blk_count; per_q <= per_block_chk; lim_q <= poll_limit;
          idx_q <= '0; seen_q <= 1'b0; err_code <= '0; fail_idx <= '0;
          st_q <= S_CLR;
        end
        S_CLR:   st_q <= S_SETUP;
        S_SETUP: st_q <= S_CONF;
        S_CONF:  begin pcnt_q <= '0; st_q <= S_POLL; end
        S_GAP:   st_q <= S_POLL;
        S_POLL: begin
          if (!rdy) begin
            if (pcnt_q + 1'b1 >= lim_q) begin
              err_code <= E_TIMEOUT; fail_idx <= idx_q; st_q <= S_FF;
            end else begin
              pcnt_q <= pcnt_q + 1'b1; st_q <= S_GAP;
            end
          end else if (per_q && code != 3'd0) begin
            err_code <= code; fail_idx <= idx_q; st_q <= S_FF;
          end else begin
            if (!per_q && code != 3'd0 && !seen_q) begin
              fail_idx <= idx_q; seen_q <= 1'b1;
            end
            if (last) begin
              if (!per_q) err_code <= code;
              st_q <= S_FF;
            end else begin
              idx_q <= idx_q + 1'b1; st_q <= S_SETUP;
            end
          end
        end
        S_FF: begin done <= 1'b1; st_q <= S_IDLE; end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r3_poll_gap: assert property (@(posedge clk) disable iff (!rst_n) bus_re |=> !bus_re);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(bus_we && bus_re));
  a_r8_done_after_ff: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_we) && $past(bus_wdata[7:0]) == 8'hFF && !busy));
  a_r4_setup_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_wdata[7:0] == 8'h20 && $past(bus_re)) |-> $past(bus_rdata[7]));
  a_r9_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |-> (pcnt_q < lim_q || lim_q == '0));
  a_r2_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_we && bus_wdata[7:0] == 8'h50));
endmodule

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
  localparam int AW = 22, DW = 16, CW = 4, PW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start = 1'b0, per_block_chk = 1'b1;
  logic [CW-1:0] blk_count = '0, blk_idx, fail_idx;
  logic [PW-1:0] poll_limit = 10'd20;
  logic [AW-1:0] blk_addr, bus_addr;
  logic          bus_we, bus_re, busy, done;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [2:0]    err_code;

  flash_erase_seq #(.AW(AW), .DW(DW), .CW(CW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
    .per_block_chk(per_block_chk), .poll_limit(poll_limit), .blk_idx(blk_idx),
    .blk_addr(blk_addr), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .err_code(err_code), .fail_idx(fail_idx));

  // address table: block i lives at (i+1)<<12, offset 3
  assign blk_addr = AW'((32'(blk_idx) + 1) * 4096 + 3);

  // device model
  logic [7:0] inj [0:15];
  logic [7:0] sr;
  int lat = 2, busy_left = 0, nreads = 0, nw = 0;
  logic [7:0]    wd [0:63];
  logic [AW-1:0] wa [0:63];
  assign bus_rdata = {8'h00, busy_left == 0, 1'b0, sr[5:1], 1'b0};

  always @(posedge clk) begin
    if (!rst_n) begin
      sr <= 8'h00; busy_left <= 0;
    end else begin
      if (bus_we) begin
        if (nw < 64) begin wd[nw] <= bus_wdata[7:0]; wa[nw] <= bus_addr; end
        nw <= nw + 1;
        if (bus_wdata[7:0] == 8'h50) sr <= 8'h00;
        if (bus_wdata[7:0] == 8'hD0) begin
          busy_left <= lat;
          sr <= sr | inj[4'(bus_addr[15:12] - 4'd1)];
        end
      end
      if (bus_re) begin
        nreads <= nreads + 1;
        if (busy_left > 0) busy_left <= busy_left - 1;
      end
    end
  end

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_inj();
    for (int i = 0; i < 16; i++) inj[i] = 8'h00;
  endtask

  task automatic run(input int n, input bit per, input int limit);
    int guard;
    @(negedge clk);
    nw = 0; nreads = 0;
    blk_count = CW'(n); per_block_chk = per; poll_limit = PW'(limit); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 3000) begin @(negedge clk); guard++; end
    chk(done === 1'b1 && busy === 1'b0, "R8 done pulse with busy low", int'(done), 1);
  endtask

  task automatic chk_seq(input int n, input string tag);
    chk(nw == 2 * n + 2, {tag, " write count"}, nw, 2 * n + 2);
    chk(wd[0] == 8'h50, {tag, " clear first"}, wd[0], 8'h50);
    for (int i = 0; i < n; i++) begin
      chk(wd[1+2*i] == 8'h20 && wa[1+2*i][15:12] == 4'(i + 1), {tag, " setup"}, wd[1+2*i], 8'h20);
      chk(wd[2+2*i] == 8'hD0 && wa[2+2*i][15:12] == 4'(i + 1), {tag, " confirm"}, wd[2+2*i], 8'hD0);
    end
    chk(wd[2*n+1] == 8'hFF, {tag, " R8 final FFh"}, wd[2*n+1], 8'hFF);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !bus_we && !bus_re, "R1 idle outputs", int'(busy), 0);
    chk(err_code == 0 && fail_idx == 0, "R1 result cleared", int'(err_code), 0);
  endtask

  task automatic t_pass_multi();
    clear_inj(); lat = 2;
    run(3, 1, 20);
    chk(err_code == 0, "R5 pass code", int'(err_code), 0);
    chk_seq(3, "R2");
    chk(nreads == 9, "R4 polls until ready", nreads, 9);
  endtask

  task automatic t_per_block_stop();
    clear_inj(); lat = 1; inj[1] = 8'h02;
    run(3, 1, 20);
    chk(err_code == 1, "R6 locked code", int'(err_code), 1);
    chk(fail_idx == 1, "R6 fail index", int'(fail_idx), 1);
    chk(nw == 6, "R6 stops after failing block", nw, 6);
    chk(wd[5] == 8'hFF, "R8 FFh after abort", wd[5], 8'hFF);
  endtask

  task automatic t_priority();
    clear_inj(); lat = 0;
    inj[0] = 8'h28; run(1, 1, 20);
    chk(err_code == 2, "R5 supply over erase", int'(err_code), 2);
    inj[0] = 8'h30; run(1, 1, 20);
    chk(err_code == 3, "R5 command sequence", int'(err_code), 3);
    inj[0] = 8'h20; run(1, 1, 20);
    chk(err_code == 4, "R5 erase failure", int'(err_code), 4);
    inj[0] = 8'h10; run(1, 1, 20);
    chk(err_code == 0, "R5 bit4 alone passes", int'(err_code), 0);
    inj[0] = 8'h2A; run(1, 1, 20);
    chk(err_code == 1, "R5 locked highest", int'(err_code), 1);
  endtask

  task automatic t_deferred();
    clear_inj(); lat = 3; inj[1] = 8'h20;
    run(3, 0, 20);
    chk_seq(3, "R7 all blocks");
    chk(err_code == 4, "R7 final decode", int'(err_code), 4);
    chk(fail_idx == 1, "R7 first failing index", int'(fail_idx), 1);
    clear_inj();
    run(2, 0, 20);
    chk(err_code == 0 && fail_idx == 0, "R2 clear-status restores pass", int'(err_code), 0);
  endtask

  task automatic t_timeout();
    clear_inj(); lat = 100;
    run(2, 1, 5);
    chk(err_code == 5, "R9 timeout code", int'(err_code), 5);
    chk(nreads == 5, "R9 exact poll count", nreads, 5);
    chk(fail_idx == 0, "R9 fail index", int'(fail_idx), 0);
    lat = 100;
    run(1, 1, 0);
    chk(nreads == 1 && err_code == 5, "R9 limit zero acts as one", nreads, 1);
  endtask

  task automatic t_ignore();
    clear_inj(); lat = 4;
    @(negedge clk);
    nw = 0;
    blk_count = 4'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk(nw == 0 && !busy, "R10 zero count ignored", nw, 0);
    blk_count = 4'd2; per_block_chk = 1'b1; poll_limit = 10'd20; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    blk_count = 4'd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    chk(nw == 6, "R10 start while busy ignored", nw, 6);
    repeat (5) @(negedge clk);
    chk(!busy && nw == 6, "R10 no restart", nw, 6);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    clear_inj();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass_multi();
    t_per_block_stop();
    t_priority();
    t_deferred();
    t_timeout();
    t_ignore();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule